// File: doc/BRIEF.md
# Sequential Multiply-Accumulate FIR Filter

This block is a finite impulse response filter that trades throughput for area. It has one multiplier and one adder, and it spends several clock cycles on each input sample. A circular sample store keeps the most recent samples. A build-time coefficient table holds one signed weight per tap. Counters address both of them, and a four-state controller sequences the work. The states are waiting, storing the sample, accumulating, and presenting the result.

A producer offers a sample with a valid strobe, and the filter takes it only while it is idle. After the computation, the filtered value sits in an output register with a valid flag. It stays there until the consumer pulses an acknowledge. Only then does the filter return to idle and take the next sample. Samples that arrive before reset count as zero, so the first results reflect only the history received so far.

Top module: `seq_mac_fir`

## Requirements
- R1: While reset is asserted and right after it is released, `in_ready` is 1, `busy` is 0, `out_valid` is 0 and `out_data` is 0.
- R2: A sample is accepted only on a rising edge where `in_valid` and `in_ready` are both 1. Values on `in_valid`/`in_data` while the block is busy have no effect on any result.
- R3: With NTAPS taps, `out_valid` first goes high exactly NTAPS+2 cycles after the cycle in which the sample was accepted.
- R4: `out_data` is the signed sum over k = 0..NTAPS-1 of c(k)·x[n-k]. Here x[n] is the newest accepted sample (signed two's complement), x[n-k] is the k-th older one, and c(k) = ((5k+3) mod 11) − 5.
- R5: While `out_valid` is 1 and `out_ack` is 0, `out_valid` stays 1 and `out_data` does not change. A cycle with `out_valid` and `out_ack` both 1 is followed by `out_valid` = 0 and `in_ready` = 1.
- R6: `busy` is 1 in every non-idle state and is always the inverse of `in_ready`.
- R7: `out_ack` has no effect while `out_valid` is 0: the block neither leaves a busy state early nor shows a result.
- R8: Full-scale samples (−2^(DW−1) and 2^(DW−1)−1) held over the whole window produce the exact sum, without wrap-around. The result is AW = DW+CW+clog2(NTAPS) bits wide.
- R9: Once more than NTAPS samples have been accepted, only the NTAPS most recent ones contribute. The store wraps circularly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Producer offers a sample |
| in_data | input | DW | Signed input sample |
| in_ready | output | 1 | Block is idle and will take a sample |
| busy | output | 1 | Block is storing, accumulating or presenting |
| out_valid | output | 1 | `out_data` holds a result awaiting acknowledge |
| out_data | output | AW | Signed filter result |
| out_ack | input | 1 | Consumer takes the result |

## Verification
The assertions assume only two things about the inputs. First, the producer may hold `in_valid` high for any number of cycles. Second, `out_ack` may arrive in any cycle, including the cycle in which `out_valid` first rises. The bench deliberately drives junk samples, a raised `in_valid` and stray acknowledges through every busy cycle before a result appears. It lowers them once the result is shown, so any effect of those inputs would show up in the latency or the sum. Hold times before the acknowledge vary from zero to three cycles across a sweep of all 256 input codes, so both the same-cycle acknowledge and the held-result cases are exercised.

// File: rtl/seq_mac_fir_pkg.sv
package seq_mac_fir_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_STORE = 2'd1,
    ST_ACCUM = 2'd2,
    ST_SHOW  = 2'd3
  } fir_state_t;

  // Build-time tap weight for tap index k
  function automatic int tap_weight(input int k);
    return ((k * 5 + 3) % 11) - 5;
  endfunction

endpackage

// File: rtl/seq_mac_fir_coef_rom.sv
module seq_mac_fir_coef_rom #(
  parameter int NTAPS = 6,
  parameter int CW    = 8,
  parameter int IW    = $clog2(NTAPS)
) (
  input  logic [IW-1:0]        idx,
  output logic signed [CW-1:0] coef
);
  import seq_mac_fir_pkg::*;

  logic signed [CW-1:0] table_w [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    assign table_w[g] = CW'(tap_weight(g));
  end

  always_comb begin
    coef = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (idx == IW'(i)) coef = table_w[i];
    end
  end

endmodule

// File: rtl/seq_mac_fir_sample_mem.sv
module seq_mac_fir_sample_mem #(
  parameter int NTAPS = 6,
  parameter int DW    = 8,
  parameter int IW    = $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  input  logic [IW-1:0]        rd_addr,
  output logic signed [DW-1:0] rd_data
);

  logic signed [DW-1:0] slot_q [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_addr == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_we) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NTAPS; i++) begin
      if (rd_addr == IW'(i)) rd_data = slot_q[i];
    end
  end

endmodule

// File: rtl/seq_mac_fir_mac.sv
module seq_mac_fir_mac #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int AW = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_clr,
  input  logic                 acc_en,
  input  logic signed [DW-1:0] samp,
  input  logic signed [CW-1:0] coef,
  output logic signed [AW-1:0] sum_d
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] acc_q;

  assign prod     = samp * coef;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign sum_d    = acc_q + prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_clr) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= sum_d;
    end
  end

endmodule

// File: rtl/seq_mac_fir_ctrl.sv
module seq_mac_fir_ctrl #(
  parameter int NTAPS = 6,
  parameter int IW    = $clog2(NTAPS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic                              out_ack,
  output logic                              cap_en,
  output logic                              wr_en,
  output logic [IW-1:0]                     wr_addr,
  output logic [IW-1:0]                     rd_addr,
  output logic [IW-1:0]                     tap_idx,
  output logic                              acc_clr,
  output logic                              acc_en,
  output logic                              out_load,
  output seq_mac_fir_pkg::fir_state_t       state
);
  import seq_mac_fir_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(NTAPS - 1);

  fir_state_t    state_q, state_d;
  logic [IW-1:0] wptr_q, wptr_d;
  logic [IW-1:0] rptr_q, rptr_d;
  logic [IW-1:0] tap_q, tap_d;
  logic          last_tap;

  assign last_tap = (tap_q == LAST);

  // next-state and control decode
  always_comb begin
    state_d  = state_q;
    cap_en   = 1'b0;
    wr_en    = 1'b0;
    acc_clr  = 1'b0;
    acc_en   = 1'b0;
    out_load = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (in_valid) begin
          cap_en  = 1'b1;
          state_d = ST_STORE;
        end
      end
      ST_STORE: begin
        wr_en   = 1'b1;
        acc_clr = 1'b1;
        state_d = ST_ACCUM;
      end
      ST_ACCUM: begin
        acc_en = 1'b1;
        if (last_tap) begin
          out_load = 1'b1;
          state_d  = ST_SHOW;
        end
      end
      ST_SHOW: begin
        if (out_ack) state_d = ST_WAIT;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  // address counters
  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    tap_d  = tap_q;
    if (state_q == ST_STORE) begin
      wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      rptr_d = wptr_q;
      tap_d  = '0;
    end else if (state_q == ST_ACCUM) begin
      rptr_d = (rptr_q == '0) ? LAST : rptr_q - 1'b1;
      tap_d  = last_tap ? '0 : tap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      wptr_q  <= '0;
      rptr_q  <= '0;
      tap_q   <= '0;
    end else begin
      state_q <= state_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      tap_q   <= tap_d;
    end
  end

  assign wr_addr = wptr_q;
  assign rd_addr = rptr_q;
  assign tap_idx = tap_q;
  assign state   = state_q;

endmodule

// File: rtl/seq_mac_fir.sv
module seq_mac_fir #(
  parameter int NTAPS = 6,
  parameter int DW    = 8,
  parameter int CW    = 8,
  localparam int IW   = $clog2(NTAPS),
  localparam int AW   = DW + CW + $clog2(NTAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          busy,
  output logic          out_valid,
  output logic [AW-1:0] out_data,
  input  logic          out_ack
);
  import seq_mac_fir_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  fir_state_t           state;
  logic                 cap_en, wr_en, acc_clr, acc_en, out_load;
  logic [IW-1:0]        wr_addr, rd_addr, tap_idx;
  logic signed [DW-1:0] x_q, rd_sample;
  logic signed [CW-1:0] coef;
  logic signed [AW-1:0] sum_d;
  logic [AW-1:0]        y_q;

  seq_mac_fir_ctrl #(.NTAPS(NTAPS), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .out_ack  (out_ack),
    .cap_en   (cap_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .tap_idx  (tap_idx),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en),
    .out_load (out_load),
    .state    (state)
  );

  // input register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      x_q <= '0;
    end else if (cap_en) begin
      x_q <= in_data;
    end
  end

  seq_mac_fir_sample_mem #(.NTAPS(NTAPS), .DW(DW), .IW(IW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (x_q),
    .rd_addr (rd_addr),
    .rd_data (rd_sample)
  );

  seq_mac_fir_coef_rom #(.NTAPS(NTAPS), .CW(CW), .IW(IW)) u_rom (
    .idx  (tap_idx),
    .coef (coef)
  );

  seq_mac_fir_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .acc_clr (acc_clr),
    .acc_en  (acc_en),
    .samp    (rd_sample),
    .coef    (coef),
    .sum_d   (sum_d)
  );

  // output register
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      y_q <= '0;
    end else if (out_load) begin
      y_q <= sum_d;
    end
  end

  assign in_ready  = (state == ST_WAIT);
  assign busy      = (state != ST_WAIT);
  assign out_valid = (state == ST_SHOW);
  assign out_data  = y_q;

endmodule

// File: rtl/seq_mac_fir_chk.sv
module seq_mac_fir_chk #(
  parameter int NTAPS = 6,
  parameter int AW    = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          busy,
  input logic          out_valid,
  input logic          out_ack,
  input logic [AW-1:0] out_data
);
  localparam int CNW = $clog2(NTAPS + 3) + 1;

  logic [CNW-1:0] since_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_accept <= '0;
    end else if (in_valid && in_ready) begin
      since_accept <= CNW'(1);
    end else if (busy && !out_valid) begin
      since_accept <= since_accept + 1'b1;
    end
  end

  assert_ready_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != busy);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !out_valid));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_accept == CNW'(NTAPS + 2)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ack) |=> (in_ready && !out_valid));

  assert_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_valid) |=> busy);

endmodule

bind seq_mac_fir seq_mac_fir_chk #(.NTAPS(NTAPS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .busy      (busy),
  .out_valid (out_valid),
  .out_ack   (out_ack),
  .out_data  (out_data)
);

// File: tb/seq_mac_fir_tb.sv
module seq_mac_fir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int AW = DW + CW + $clog2(NT);

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          in_ready;
  logic          busy;
  logic          out_valid;
  logic [AW-1:0] out_data;
  logic          out_ack;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int sent   = 0;
  int hist [NT];

  seq_mac_fir #(.NTAPS(NT), .DW(DW), .CW(CW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ack   (out_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int wt(input int k);
    return ((k * 5 + 3) % 11) - 5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int x, input int hold);
    int n;
    int exp;
    bit got;
    int res;
    @(negedge clk);
    check(in_ready == 1'b1 && busy == 1'b0, "R6", "idle before send", busy, 0);
    in_valid = 1'b1;
    in_data  = DW'(x);
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    sent++;
    exp = 0;
    for (int k = 0; k < NT; k++) exp += wt(k) * hist[k];
    n = 0;
    got = 1'b0;
    while (!got && n < 40) begin
      @(negedge clk);
      n++;
      if (out_valid) begin
        got = 1'b1;
      end else begin
        check(busy == 1'b1 && in_ready == 1'b0, "R6", "busy while working", busy, 1);
        // junk on the input side and stray ack while busy: must be ignored (R2, R7)
        in_valid = 1'b1;
        in_data  = DW'(x * 37 + n * 11 + 5);
        out_ack  = 1'b1;
      end
    end
    in_valid = 1'b0;
    out_ack  = 1'b0;
    check(n == NT + 2, "R3", "cycles to result", n, NT + 2);
    res = int'($signed(out_data));
    if (sent > NT)
      check(res == exp, "R9", "windowed sum", res, exp);
    else
      check(res == exp, "R4", "filter sum", res, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && int'($signed(out_data)) == exp, "R5",
            "held result", int'($signed(out_data)), exp);
    end
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R5", "released after ack",
          out_valid, 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    out_ack  = 1'b0;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && busy == 1'b0, "R1", "ready in reset", in_ready, 1);
    check(out_valid == 1'b0 && out_data == '0, "R1", "output in reset", out_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && out_data == '0, "R1",
          "state after release", out_data, 0);

    // stray ack while idle (R7)
    out_ack = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "ack in idle ignored", out_valid, 0);
    out_ack = 1'b0;

    // impulse: results walk through the tap weights (R4)
    send(1, 1);
    for (int i = 0; i < NT; i++) send(0, i % 3);

    // full-scale extremes (R8)
    for (int i = 0; i < NT + 1; i++) send(-128, 0);
    check(int'($signed(out_data)) == -128 * (-2 + 3 - 3 + 2 - 4 + 1), "R8",
          "negative full scale", int'($signed(out_data)), -128 * (-3));
    for (int i = 0; i < NT + 1; i++) send(127, 1);
    check(int'($signed(out_data)) == 127 * (-3), "R8",
          "positive full scale", int'($signed(out_data)), 127 * (-3));
    for (int i = 0; i < 2 * NT; i++) send((i % 2 == 0) ? -128 : 127, 2);

    // sweep of every input code (R9 once the window has wrapped)
    for (int v = -128; v < 128; v++) send(v, (v + 128) % 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule